// File: doc/BRIEF.md
# Packet-Granular Multi-Buffer FIFO

This block is a FIFO whose storage is one memory cut into `NBUF` equal packet buffers of `PKT_WORDS` words each. A producer fills the buffer it currently owns one word per cycle. A consumer drains buffers one word per cycle. No data is ever copied. When the producer writes the final word of a buffer, the buffer index is handed to the consumer as a registered commit. When the consumer reads the final word of a buffer, that buffer is handed back to the producer. Both sides step through the buffers in round-robin order. Both run on one clock.

The status flags are active low and count whole packets. `full_n` high means at least one whole buffer is free to fill. `empty_n` high means at least one whole committed packet is ready to read. An external master can sustain one word per clock, so it can keep `wr_en` or `rd_en` held for a complete burst. If `early_en` is set, each flag asserts one word ahead of the true condition, which gives the master one extra cycle to react. In that mode the flagged last word is still accepted. `PKT_WORDS` must be a power of two from 2 up to 1024. `NBUF` ranges from 2 to 4.

Top module: `pktbuf_fifo`

## Requirements
- R1: After reset, `full_n` is 1, `empty_n` is 0, and both `wr_err` and `rd_err` are 0. Both flags are active low: 0 means the condition holds.
- R2: `rd_data` always shows the oldest unread committed word while `empty_n` is 1. Words come out in the order they were written, across buffer boundaries, with the buffers used round-robin.
- R3: A partly written packet cannot be read. `empty_n` stays 0 until the last word of a packet is written, and it is 1 on the cycle after that write.
- R4: Once `NBUF` packets are committed and none has been released, `full_n` is 0 on the cycle after the last of those words is written.
- R5: A buffer returns to the producer only after its last word is read. `full_n` stays 0 while a packet is only partly read, and it is 1 on the cycle after the final word of that packet is read.
- R6: A write while all buffers are committed has no effect: the word is never stored and no later read returns it. It also sets `wr_err`, which stays 1 until reset.
- R7: A read while no packet is committed has no effect: the read position does not move. It also sets `rd_err`, which stays 1 until reset.
- R8: With `early_en` set, `full_n` goes to 0 once exactly one free word slot is left. A write into that slot is still accepted and is later read back.
- R9: With `early_en` set, `empty_n` goes to 0 while the last readable word is being presented. A read of that word is still accepted and returns it.
- R10: If one packet is committed and another is released in the same cycle, the number of committed packets does not change, and neither flag toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| early_en | input | 1 | When set, both flags assert one word early |
| wr_en | input | 1 | Write one word this cycle |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Consume the presented word this cycle |
| rd_data | output | DATA_W | Oldest unread committed word |
| full_n | output | 1 | Low when no whole buffer is free (or one word early) |
| empty_n | output | 1 | Low when no whole packet is ready (or one word early) |
| wr_err | output | 1 | Sticky: a write was attempted while full |
| rd_err | output | 1 | Sticky: a read was attempted while empty |

## Verification
A commit and a release can happen in the same clock cycle. This occurs when the producer writes the last word of one buffer in the same cycle that the consumer reads the last word of another. The bench provokes it by writing and reading together for a whole packet while exactly one packet is outstanding, which lines up both final words in the same cycle. The bench's own occupancy model must then show no change in either flag, and every word read in that burst must match the scoreboard.

// File: rtl/pktbuf_fifo_pkg.sv
package pktbuf_fifo_pkg;

    // Ownership state of the buffer pool, seen from the consumer side
    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,   // no committed packet
        OCC_SOME = 2'd1,   // at least one committed packet, at least one free buffer
        OCC_ALL  = 2'd2    // every buffer committed to the consumer
    } occ_state_e;

endpackage

// File: rtl/pktbuf_fifo_ptr.sv
// Word offset plus buffer index for one side; emits a handoff on the last word.
module pktbuf_fifo_ptr #(
    parameter int PKT_WORDS = 8,
    parameter int NBUF      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv,
    output logic [$clog2(PKT_WORDS)-1:0] off,
    output logic [$clog2(NBUF)-1:0]      bidx,
    output logic                         at_last,
    output logic                         handoff
);
    localparam int OFF_W = $clog2(PKT_WORDS);
    localparam int BUF_W = $clog2(NBUF);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(PKT_WORDS - 1);
    localparam logic [BUF_W-1:0] BUF_LAST = BUF_W'(NBUF - 1);

    assign at_last = (off == OFF_LAST);
    assign handoff = adv && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off  <= '0;
            bidx <= '0;
        end else if (adv) begin
            if (at_last) begin
                off  <= '0;
                bidx <= (bidx == BUF_LAST) ? '0 : bidx + BUF_W'(1);
            end else begin
                off  <= off + OFF_W'(1);
            end
        end
    end
endmodule

// File: rtl/pktbuf_fifo_mem.sv
// Shared buffer storage: one write port, one combinational read port.
module pktbuf_fifo_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/pktbuf_fifo_owner.sv
// Tracks how many buffers the consumer owns and derives the packet flags.
module pktbuf_fifo_owner
    import pktbuf_fifo_pkg::*;
#(
    parameter int NBUF = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic                       rel,
    input  logic                       wr_last,
    input  logic                       rd_last,
    input  logic                       early_en,
    output logic [$clog2(NBUF+1)-1:0]  occ,
    output logic                       can_wr,
    output logic                       can_rd,
    output logic                       full_n,
    output logic                       empty_n
);
    localparam int CNT_W = $clog2(NBUF + 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] ALL_BUT_1 = CNT_W'(NBUF - 1);

    occ_state_e            state, nstate;
    logic [CNT_W-1:0]      nocc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OCC_NONE;
            occ   <= '0;
        end else begin
            state <= nstate;
            occ   <= nocc;
        end
    end

    // Transitions
    always_comb begin
        nstate = state;
        nocc   = occ;
        unique case (state)
            OCC_NONE: begin
                if (commit) begin                       // T_FIRST
                    nocc   = ONE;
                    nstate = OCC_SOME;
                end
            end
            OCC_SOME: begin
                if (commit && !rel) begin               // T_ADD / T_FILL
                    nocc   = occ + ONE;
                    nstate = (occ == ALL_BUT_1) ? OCC_ALL : OCC_SOME;
                end else if (rel && !commit) begin      // T_TAKE / T_DRAIN
                    nocc   = occ - ONE;
                    nstate = (occ == ONE) ? OCC_NONE : OCC_SOME;
                end                                     // T_SWAP: both, hold
            end
            OCC_ALL: begin
                if (rel) begin                          // T_FREE
                    nocc   = occ - ONE;
                    nstate = OCC_SOME;
                end
            end
            default: begin
                nocc   = '0;
                nstate = OCC_NONE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        can_wr  = (state != OCC_ALL);
        can_rd  = (state != OCC_NONE);
        full_n  = !((state == OCC_ALL) ||
                    (early_en && (occ == ALL_BUT_1) && wr_last));
        empty_n = !((state == OCC_NONE) ||
                    (early_en && (occ == ONE) && rd_last));
    end
endmodule

// File: rtl/pktbuf_fifo.sv
module pktbuf_fifo #(
    parameter int DATA_W    = 16,
    parameter int PKT_WORDS = 8,
    parameter int NBUF      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_n,
    output logic              empty_n,
    output logic              wr_err,
    output logic              rd_err
);
    localparam int OFF_W  = $clog2(PKT_WORDS);
    localparam int BUF_W  = $clog2(NBUF);
    localparam int ADDR_W = OFF_W + BUF_W;
    localparam int DEPTH  = NBUF * PKT_WORDS;
    localparam int CNT_W  = $clog2(NBUF + 1);

    logic [OFF_W-1:0] woff, roff;
    logic [BUF_W-1:0] wbuf, rbuf;
    logic             wlast, rlast, w_hand, r_hand;
    logic             can_wr, can_rd, wr_ok, rd_ok;
    logic [CNT_W-1:0] occ;

    assign wr_ok = wr_en && can_wr;
    assign rd_ok = rd_en && can_rd;

    pktbuf_fifo_ptr #(.PKT_WORDS(PKT_WORDS), .NBUF(NBUF)) u_wptr (
        .clk(clk), .rst_n(rst_n), .adv(wr_ok),
        .off(woff), .bidx(wbuf), .at_last(wlast), .handoff(w_hand)
    );

    pktbuf_fifo_ptr #(.PKT_WORDS(PKT_WORDS), .NBUF(NBUF)) u_rptr (
        .clk(clk), .rst_n(rst_n), .adv(rd_ok),
        .off(roff), .bidx(rbuf), .at_last(rlast), .handoff(r_hand)
    );

    // Buffer index selects the slice; power-of-two packet size keeps it a concat
    pktbuf_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .we(wr_ok),
        .waddr({wbuf, woff}), .wdata(wr_data),
        .raddr({rbuf, roff}), .rdata(rd_data)
    );

    pktbuf_fifo_owner #(.NBUF(NBUF)) u_own (
        .clk(clk), .rst_n(rst_n),
        .commit(w_hand), .rel(r_hand),
        .wr_last(wlast), .rd_last(rlast), .early_en(early_en),
        .occ(occ), .can_wr(can_wr), .can_rd(can_rd),
        .full_n(full_n), .empty_n(empty_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            if (wr_en && !can_wr) wr_err <= 1'b1;
            if (rd_en && !can_rd) rd_err <= 1'b1;
        end
    end
endmodule

// File: rtl/pktbuf_fifo_chk.sv
module pktbuf_fifo_chk #(
    parameter int NBUF      = 2,
    parameter int PKT_WORDS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         early_en,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic                         full_n,
    input logic                         wr_err,
    input logic                         rd_err,
    input logic                         can_wr,
    input logic                         can_rd,
    input logic                         w_hand,
    input logic                         r_hand,
    input logic [$clog2(PKT_WORDS)-1:0] woff,
    input logic [$clog2(PKT_WORDS)-1:0] roff,
    input logic [$clog2(NBUF+1)-1:0]    occ
);
    localparam int CNT_W = $clog2(NBUF + 1);

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !can_wr) |=> (wr_err && $stable(woff))); // R6
    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !can_rd) |=> (rd_err && $stable(roff))); // R7
    AST_WR_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err); // R6
    AST_RD_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> rd_err); // R7
    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (w_hand && r_hand) |=> $stable(occ)); // R10
    AST_COMMIT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (w_hand && !r_hand) |=> (occ == $past(occ) + CNT_W'(1))); // R3
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (occ <= CNT_W'(NBUF))); // R4
    AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !r_hand && !early_en) |=> !full_n); // R5
endmodule

bind pktbuf_fifo pktbuf_fifo_chk #(.NBUF(NBUF), .PKT_WORDS(PKT_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .early_en(early_en),
    .wr_en(wr_en), .rd_en(rd_en), .full_n(full_n),
    .wr_err(wr_err), .rd_err(rd_err),
    .can_wr(can_wr), .can_rd(can_rd),
    .w_hand(w_hand), .r_hand(r_hand),
    .woff(woff), .roff(roff), .occ(occ)
);

// File: tb/pktbuf_fifo_tb.sv
`timescale 1ns/1ps
module pktbuf_fifo_tb;
    localparam int DW  = 16;
    localparam int PKT = 8;
    localparam int NB  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          early_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          full_n, empty_n, wr_err, rd_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt = 0, m_woff = 0, m_roff = 0;
    bit m_werr = 0, m_rerr = 0;
    logic [DW-1:0] nxt = 16'h1000;
    logic [DW-1:0] sb[$];

    always #4 clk = ~clk;

    pktbuf_fifo #(.DATA_W(DW), .PKT_WORDS(PKT), .NBUF(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .early_en(early_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .full_n(full_n), .empty_n(empty_n), .wr_err(wr_err), .rd_err(rd_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_full_n();
        return !((m_cnt == NB) ||
                 (early_en && m_cnt == NB - 1 && m_woff == PKT - 1));
    endfunction

    function automatic bit exp_empty_n();
        return !((m_cnt == 0) ||
                 (early_en && m_cnt == 1 && m_roff == PKT - 1));
    endfunction

    // Driver + monitor for one cycle; called at a falling edge
    task automatic step(input bit we, input bit re, input string tag);
        bit wacc, racc, wh, rh;
        logic [DW-1:0] wd;
        wd = nxt;
        nxt = nxt + 1'b1;
        wacc = we && (m_cnt < NB);
        racc = re && (m_cnt > 0);
        wr_en = we;
        wr_data = wd;
        rd_en = re;
        if (racc) chk({tag, " rd_data"}, 32'(rd_data), 32'(sb.pop_front()));
        if (wacc) sb.push_back(wd);
        if (we && !wacc) m_werr = 1'b1;
        if (re && !racc) m_rerr = 1'b1;
        wh = wacc && (m_woff == PKT - 1);
        rh = racc && (m_roff == PKT - 1);
        if (wacc) m_woff = wh ? 0 : m_woff + 1;
        if (racc) m_roff = rh ? 0 : m_roff + 1;
        m_cnt = m_cnt + int'(wh) - int'(rh);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk({tag, " full_n"},  32'(full_n),  32'(exp_full_n()));
        chk({tag, " empty_n"}, 32'(empty_n), 32'(exp_empty_n()));
        chk({tag, " wr_err"},  32'(wr_err),  32'(m_werr));
        chk({tag, " rd_err"},  32'(rd_err),  32'(m_rerr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 full_n", 32'(full_n), 32'd1);
        chk("R1 empty_n", 32'(empty_n), 32'd0);
        chk("R1 wr_err", 32'(wr_err), 32'd0);
        chk("R1 rd_err", 32'(rd_err), 32'd0);
        // R7: read with nothing committed
        step(1'b0, 1'b1, "R7");
        // R3: partial packet stays invisible
        for (int i = 0; i < PKT; i++) step(1'b1, 1'b0, "R3");
        // R4: second packet fills the pool
        for (int i = 0; i < PKT; i++) step(1'b1, 1'b0, "R4");
        // R6: write while full is dropped
        step(1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, "R6");
        // R5: full held until the last word of the oldest packet is read
        for (int i = 0; i < PKT; i++) step(1'b0, 1'b1, "R5");
        // R10: commit and release land in one cycle
        for (int i = 0; i < PKT; i++) step(1'b1, 1'b1, "R10");
        // R2: drain in order
        for (int i = 0; i < PKT; i++) step(1'b0, 1'b1, "R2");
        // R8: early full
        early_en = 1'b1;
        for (int i = 0; i < 2 * PKT; i++) step(1'b1, 1'b0, "R8");
        // R9: early empty, last word still read
        for (int i = 0; i < 2 * PKT; i++) step(1'b0, 1'b1, "R9");
        early_en = 1'b0;
        @(negedge clk);
        chk("R2 drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule